// File: doc/BRIEF.md
# Audio Concealment and Mute Unit

This block sits after error correction in a compact-disc audio path. It receives left and right 16-bit two's-complement samples over an 8-bit bus. Each sample word is sent as three transfers: an error-pointer byte, then the low byte, then the high byte. The block replaces samples that correction could not repair, then applies muting and a fixed attenuation before handing each sample on with a channel tag.

Concealment runs separately for each channel and looks one sample ahead. A sample is released only when the next sample of the same channel has arrived, so the next good value is known when a flagged sample is repaired.

- An isolated flagged sample becomes the mean of its two neighbours.
- In a run of flagged samples, every sample except the last repeats the last good value.
- The last flagged sample of a run becomes the mean of that held value and the following good sample.

Muting can act at once. It can also wait until the sample is close to zero, so that the cut does not click. Attenuation lowers the level by 12 dB.

Top module: `audio_conceal_mute`

## Requirements
- R1: A transfer with `in_first`=1 carries the error pointer; only its bit 0 counts (1 = flagged). The next two transfers carry the low byte and then the high byte. The word completes on the high byte.
- R2: A sample of a channel is released when the next sample of the same channel completes. `out_valid` rises two clock edges after the edge that accepts that high byte, and is high for one cycle.
- R3: With mute and attenuation off, an unflagged sample appears at the output unchanged.
- R4: A flagged sample followed by an unflagged sample N is output as floor((H+N)/2). H is the last unflagged sample output on that channel. This covers both an isolated error and the last sample of a run.
- R5: A flagged sample followed by another flagged sample is output as H.
- R6: A flagged sample with no unflagged sample on its channel since reset is output as zero.
- R7: `out_chan` is 0 for a right-channel sample and 1 for a left-channel sample. The two channels keep separate history.
- R8: With `zc_en`=0, every sample that leaves the output stage while `mute`=1 is zero.
- R9: With `zc_en`=1 and `mute`=1, output passes unchanged until a concealed sample has its upper 6 bits all 0 or all 1. That sample and every later one are zero while `mute` stays 1.
- R10: When `mute` returns to 0, the mute state clears and samples pass again.
- R11: With `att_en`=1 and no mute, the output is the concealed sample shifted right arithmetically by 2 (floor).
- R12: While `rst` is high, `out_valid` is 0. Reset clears both channels' history and any waiting sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transfer present on `in_byte` |
| in_first | input | 1 | Transfer is the error-pointer byte of a word |
| in_chan | input | 1 | Channel of the word (0 right, 1 left), taken with the pointer byte |
| in_byte | input | 8 | Bus byte |
| mute | input | 1 | Mute request |
| zc_en | input | 1 | Delay muting until a near-zero sample |
| att_en | input | 1 | 12 dB attenuation |
| out_valid | output | 1 | Output sample valid |
| out_chan | output | 1 | Channel tag, high for left |
| out_sample | output | 16 | Concealed, muted and attenuated sample |

## Verification
A corrupted held value or a lost pointer bit shows up at the next flagged sample on that channel. It appears one sample period later, as a wrong hold or a wrong mean. The flag patterns are swept over every five-sample combination, so every run length and position meets a check. A stuck or stale mute state shows as zero or non-zero samples on the first output after `mute` or `zc_en` changes. Mixing up the per-channel history shows as a sample taking its value from the other channel.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_BUS_W    = 8;
  localparam int DEF_NCH      = 2;
  localparam int DEF_ZC_BITS  = 6;
  localparam int DEF_ATT_SH   = 2;

  typedef enum logic [1:0] {
    PICK_PASS = 2'd0,
    PICK_AVG  = 2'd1,
    PICK_HOLD = 2'd2,
    PICK_ZERO = 2'd3
  } pick_e;
endpackage

// File: rtl/acm_word_assembler.sv
module acm_word_assembler #(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8,
  parameter int CH_W     = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_first,
  input  logic [CH_W-1:0]     in_chan,
  input  logic [BUS_W-1:0]    in_byte,
  output logic                w_valid,
  output logic                w_bad,
  output logic [CH_W-1:0]     w_chan,
  output logic [SAMPLE_W-1:0] w_data
);
  localparam int BEATS = SAMPLE_W / BUS_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0]    beat_q;
  logic                armed_q;
  logic                bad_q;
  logic [CH_W-1:0]     chan_q;
  logic [SAMPLE_W-1:0] part_q;
  logic [SAMPLE_W-1:0] part_d;

  // lower bytes first: each data beat fills the next byte lane
  always_comb begin
    part_d = part_q;
    part_d[beat_q*BUS_W +: BUS_W] = in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      armed_q <= 1'b0;
      bad_q   <= 1'b0;
      chan_q  <= '0;
      part_q  <= '0;
      w_valid <= 1'b0;
      w_bad   <= 1'b0;
      w_chan  <= '0;
      w_data  <= '0;
    end else begin
      w_valid <= 1'b0;
      if (in_valid) begin
        if (in_first) begin
          armed_q <= 1'b1;
          bad_q   <= in_byte[0];
          chan_q  <= in_chan;
          beat_q  <= '0;
        end else if (armed_q) begin
          part_q <= part_d;
          if (beat_q == LAST_BEAT) begin
            w_valid <= 1'b1;
            w_bad   <= bad_q;
            w_chan  <= chan_q;
            w_data  <= part_d;
            armed_q <= 1'b0;
            beat_q  <= '0;
          end else begin
            beat_q <= beat_q + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/acm_concealer.sv
module acm_concealer
  import acm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NCH      = 2,
  parameter int CH_W     = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                w_valid,
  input  logic                w_bad,
  input  logic [CH_W-1:0]     w_chan,
  input  logic [SAMPLE_W-1:0] w_data,
  output logic                c_valid,
  output logic [CH_W-1:0]     c_chan,
  output logic [SAMPLE_W-1:0] c_data
);
  logic [NCH-1:0]      pend_v;
  logic [NCH-1:0]      pend_bad;
  logic [NCH-1:0]      hold_ok;
  logic [SAMPLE_W-1:0] pend_val [NCH];
  logic [SAMPLE_W-1:0] hold_val [NCH];

  // per-channel history: one waiting sample plus the last good value
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = w_valid && (w_chan == CH_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_v[g]   <= 1'b0;
        pend_bad[g] <= 1'b0;
        pend_val[g] <= '0;
        hold_ok[g]  <= 1'b0;
        hold_val[g] <= '0;
      end else if (hit) begin
        pend_v[g]   <= 1'b1;
        pend_bad[g] <= w_bad;
        pend_val[g] <= w_data;
        if (pend_v[g] && !pend_bad[g]) begin
          hold_ok[g]  <= 1'b1;
          hold_val[g] <= pend_val[g];
        end
      end
    end
  end

  logic                      sel_v, sel_bad, sel_hok;
  logic [SAMPLE_W-1:0]       sel_val, sel_hold;
  logic signed [SAMPLE_W:0]  sum_w;
  logic [SAMPLE_W-1:0]       mean_v;
  pick_e                     pick;
  logic [SAMPLE_W-1:0]       pick_val;

  always_comb begin
    sel_v    = pend_v[w_chan];
    sel_bad  = pend_bad[w_chan];
    sel_hok  = hold_ok[w_chan];
    sel_val  = pend_val[w_chan];
    sel_hold = hold_val[w_chan];
    sum_w    = $signed({sel_hold[SAMPLE_W-1], sel_hold}) +
               $signed({w_data[SAMPLE_W-1], w_data});
    mean_v   = sum_w[SAMPLE_W:1];
    if (!sel_bad)      pick = PICK_PASS;
    else if (!sel_hok) pick = PICK_ZERO;
    else if (w_bad)    pick = PICK_HOLD;
    else               pick = PICK_AVG;
    case (pick)
      PICK_PASS: pick_val = sel_val;
      PICK_AVG:  pick_val = mean_v;
      PICK_HOLD: pick_val = sel_hold;
      default:   pick_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_valid <= 1'b0;
      c_chan  <= '0;
      c_data  <= '0;
    end else begin
      c_valid <= w_valid && sel_v;
      if (w_valid && sel_v) begin
        c_chan <= w_chan;
        c_data <= pick_val;
      end
    end
  end
endmodule

// File: rtl/acm_mute_atten.sv
module acm_mute_atten #(
  parameter int SAMPLE_W = 16,
  parameter int CH_W     = 1,
  parameter int ZC_BITS  = 6,
  parameter int ATT_SH   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                c_valid,
  input  logic [CH_W-1:0]     c_chan,
  input  logic [SAMPLE_W-1:0] c_data,
  input  logic                mute,
  input  logic                zc_en,
  input  logic                att_en,
  output logic                mute_held,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_chan,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic [ZC_BITS-1:0]         top_bits;
  logic                       near_zero;
  logic                       silence;
  logic signed [SAMPLE_W-1:0] att_v;

  always_comb begin
    top_bits  = c_data[SAMPLE_W-1 -: ZC_BITS];
    near_zero = (&top_bits) || !(|top_bits);
    silence   = mute && (!zc_en || mute_held || near_zero);
    att_v     = $signed(c_data) >>> ATT_SH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_held  <= 1'b0;
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
    end else begin
      mute_held <= mute && (mute_held || (c_valid && (near_zero || !zc_en)));
      out_valid <= c_valid;
      if (c_valid) begin
        out_chan <= c_chan;
        if (silence)     out_sample <= '0;
        else if (att_en) out_sample <= att_v;
        else             out_sample <= c_data;
      end
    end
  end
endmodule

// File: rtl/audio_conceal_mute.sv
module audio_conceal_mute
  import acm_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int BUS_W    = DEF_BUS_W,
  parameter int NCH      = DEF_NCH,
  parameter int ZC_BITS  = DEF_ZC_BITS,
  parameter int ATT_SH   = DEF_ATT_SH,
  parameter int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_first,
  input  logic [CH_W-1:0]     in_chan,
  input  logic [BUS_W-1:0]    in_byte,
  input  logic                mute,
  input  logic                zc_en,
  input  logic                att_en,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_chan,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic                w_valid, w_bad;
  logic [CH_W-1:0]     w_chan;
  logic [SAMPLE_W-1:0] w_data;
  logic                c_valid;
  logic [CH_W-1:0]     c_chan;
  logic [SAMPLE_W-1:0] c_data;
  logic                mute_held;

  acm_word_assembler #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W), .CH_W(CH_W)) u_asm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_chan(in_chan), .in_byte(in_byte),
    .w_valid(w_valid), .w_bad(w_bad), .w_chan(w_chan), .w_data(w_data));

  acm_concealer #(.SAMPLE_W(SAMPLE_W), .NCH(NCH), .CH_W(CH_W)) u_conc (
    .clk(clk), .rst(rst), .w_valid(w_valid), .w_bad(w_bad),
    .w_chan(w_chan), .w_data(w_data),
    .c_valid(c_valid), .c_chan(c_chan), .c_data(c_data));

  acm_mute_atten #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W), .ZC_BITS(ZC_BITS), .ATT_SH(ATT_SH)) u_mute (
    .clk(clk), .rst(rst), .c_valid(c_valid), .c_chan(c_chan), .c_data(c_data),
    .mute(mute), .zc_en(zc_en), .att_en(att_en), .mute_held(mute_held),
    .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample));
endmodule

// File: rtl/acm_checker.sv
module acm_checker #(
  parameter int SAMPLE_W = 16,
  parameter int CH_W     = 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_first,
  input logic                mute,
  input logic                zc_en,
  input logic                att_en,
  input logic                w_valid,
  input logic [CH_W-1:0]     w_chan,
  input logic                c_valid,
  input logic [CH_W-1:0]     c_chan,
  input logic                mute_held,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_sample
);
  assert_word_on_data_R1: assert property (@(posedge clk) disable iff (rst)
    w_valid |-> $past(in_valid && !in_first));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(w_valid, 2));

  assert_chan_kept_R7: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> (c_chan == $past(w_chan)));

  assert_hard_mute_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mute && !zc_en)) |-> (out_sample == '0));

  assert_held_mute_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mute && mute_held)) |-> (out_sample == '0));

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(mute) |-> !mute_held);

  assert_atten_sign_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(att_en && !mute)) |->
      (out_sample[SAMPLE_W-1] == out_sample[SAMPLE_W-2] &&
       out_sample[SAMPLE_W-2] == out_sample[SAMPLE_W-3]));
endmodule

bind audio_conceal_mute acm_checker #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
  .mute(mute), .zc_en(zc_en), .att_en(att_en),
  .w_valid(w_valid), .w_chan(w_chan), .c_valid(c_valid), .c_chan(c_chan),
  .mute_held(mute_held), .out_valid(out_valid), .out_sample(out_sample));

// File: tb/tb_audio_conceal_mute.sv
module tb_audio_conceal_mute;
  localparam int CLK_PERIOD = 10;
  localparam int QN = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_first = 1'b0;
  logic [0:0]  in_chan = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        mute = 1'b0, zc_en = 1'b0, att_en = 1'b0;
  logic        out_valid;
  logic [0:0]  out_chan;
  logic [15:0] out_sample;

  audio_conceal_mute dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_chan(in_chan), .in_byte(in_byte), .mute(mute), .zc_en(zc_en),
    .att_en(att_en), .out_valid(out_valid), .out_chan(out_chan),
    .out_sample(out_sample));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  bit      m_pv[2], m_pb[2], m_hok[2], m_ma;
  shortint m_pval[2], m_hold[2];
  shortint e_val[QN];
  bit      e_ch[QN];
  string   e_tag[QN];
  int      n_exp = 0;
  shortint g_val[QN];
  bit      g_ch[QN];
  int      n_got = 0;
  string   note = "";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && n_got < QN) begin
      g_val[n_got] = shortint'(out_sample);
      g_ch[n_got]  = out_chan[0];
      n_got++;
    end
  end

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_pv[c] = 0; m_pb[c] = 0; m_hok[c] = 0; m_pval[c] = 0; m_hold[c] = 0;
    end
    m_ma = 0;
  endtask

  task automatic beat(input bit first, input bit ch, input logic [7:0] b);
    in_valid = 1'b1; in_first = first; in_chan = ch; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  // R1: pointer byte carries the flag in bit 0, other bits are junk
  task automatic send(input bit ch, input bit bad, input shortint val, input bit chk_lat);
    shortint r; string tg; bit nz, sil;
    bit had = m_pv[ch];
    if (m_pv[ch]) begin
      if (!m_pb[ch]) begin
        r = m_pval[ch]; tg = "R3"; m_hold[ch] = m_pval[ch]; m_hok[ch] = 1;
      end else if (!m_hok[ch]) begin
        r = 0; tg = "R6";
      end else if (bad) begin
        r = m_hold[ch]; tg = "R5";
      end else begin
        r = shortint'((int'(m_hold[ch]) + int'(val)) >>> 1); tg = "R4";
      end
      nz  = (r[15:10] == 6'h00) || (r[15:10] == 6'h3f);
      sil = mute && (!zc_en || m_ma || nz);
      m_ma = mute && (m_ma || nz || !zc_en);
      if (sil) begin r = 0; tg = zc_en ? "R9" : "R8"; end
      else if (att_en) begin r = shortint'(int'(r) >>> 2); tg = "R11"; end
      e_val[n_exp] = r; e_ch[n_exp] = ch; e_tag[n_exp] = {tg, note};
      n_exp++;
    end
    m_pv[ch] = 1; m_pb[ch] = bad; m_pval[ch] = val;
    beat(1'b1, ch, {(ch ? 7'h2A : 7'h55), bad});
    beat(1'b0, ch, val[7:0]);
    beat(1'b0, ch, val[15:8]);
    @(negedge clk);
    if (chk_lat) check(out_valid == 1'b0, "R2 early", int'(out_valid), 0);
    @(negedge clk);
    if (chk_lat) check(out_valid == had, "R2 on time", int'(out_valid), int'(had));
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12 reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 latency, R3 pass-through, R7 tags
    send(1'b0, 1'b0, 16'sd1234, 1'b1);
    send(1'b0, 1'b0, -16'sd777, 1'b1);
    send(1'b1, 1'b1, 16'sd500, 1'b0);    // R6: left has no good history
    send(1'b1, 1'b0, 16'sd32767, 1'b0);
    send(1'b1, 1'b1, 16'sd0, 1'b0);
    send(1'b1, 1'b0, 16'sd32767, 1'b0);  // R4 with extremes
    send(1'b0, 1'b1, 16'sd9, 1'b0);
    send(1'b0, 1'b0, -16'sd32768, 1'b0); // R4 negative mean floors

    // sweep every 5-sample flag pattern on both channels (R4 R5 R3 R7)
    for (int pat = 0; pat < 32; pat++) begin
      for (int k = 0; k < 5; k++) begin
        send(1'b0, pat[k], shortint'(pat*1031 + k*7919 - 16000), 1'b0);
        send(1'b1, pat[(k+2)%5], shortint'(pat*577 - k*6151 + 9000), 1'b0);
      end
    end
    send(1'b0, 1'b0, 16'sd100, 1'b0);
    send(1'b1, 1'b0, 16'sd200, 1'b0);

    // R11 attenuation
    att_en = 1'b1;
    for (int k = 0; k < 8; k++)
      send(k[0], k[1] & k[2], shortint'(k*8191 - 30001), 1'b0);
    att_en = 1'b0;

    // R8 immediate mute, then R10 release
    mute = 1'b1;
    for (int k = 0; k < 4; k++) send(k[0], 1'b0, shortint'(12000 + k*999), 1'b0);
    mute = 1'b0; note = " R10";
    for (int k = 0; k < 4; k++) send(k[0], 1'b0, shortint'(-14000 + k*3), 1'b0);
    note = "";

    // R9 zero-cross mute: large values pass, near-zero starts mute, sticky
    zc_en = 1'b1; mute = 1'b1;
    send(1'b0, 1'b0, 16'sd20000, 1'b0);
    send(1'b0, 1'b0, 16'sd21000, 1'b0);
    send(1'b0, 1'b0, 16'sd291, 1'b0);
    send(1'b0, 1'b0, -16'sd25000, 1'b0);
    send(1'b0, 1'b0, 16'sd30000, 1'b0);
    send(1'b0, 1'b0, -16'sd120, 1'b0);
    mute = 1'b0; note = " R10";
    send(1'b0, 1'b0, 16'sd15000, 1'b0);
    send(1'b0, 1'b0, 16'sd16000, 1'b0);
    note = "";
    mute = 1'b1;
    send(1'b0, 1'b0, -16'sd30000, 1'b0);
    send(1'b0, 1'b0, -16'sd60, 1'b0);
    mute = 1'b0; zc_en = 1'b0;
    send(1'b0, 1'b0, 16'sd1, 1'b0);

    // R12 reset clears history: flagged sample afterwards outputs zero (R6)
    rst = 1'b1; model_clear();
    @(negedge clk);
    check(out_valid == 1'b0, "R12 in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    send(1'b1, 1'b1, 16'sd4444, 1'b0);
    send(1'b1, 1'b0, 16'sd4000, 1'b0);
    send(1'b1, 1'b0, 16'sd4000, 1'b0);

    repeat (6) @(negedge clk);
    check(n_got == n_exp, "R2 output count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(g_val[i] == e_val[i], {e_tag[i], " value"}, int'(g_val[i]), int'(e_val[i]));
      check(g_ch[i] == e_ch[i], "R7 channel tag", int'(g_ch[i]), int'(e_ch[i]));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule